// File: doc/BRIEF.md
# Addressed 16-bit SPI Frame Slave

This block is the serial front end of a driver chip. It receives 16-bit frames from a host. Each frame is an instruction byte followed by a data byte. The first two instruction bits carry a chip address. The slave drives SO only once that address has matched. While the instruction shifts in, it returns a fixed check byte. That byte carries a flag reporting whether the previous access was rejected. It then returns the byte selected by the instruction: a fixed identifier, a revision byte, or the diagnostic value presented on `diag_i`.

SCK, SS and SI are sampled in the system clock domain, which must run at least eight times faster than SCK. SI is taken on falling SCK edges and SO moves on rising ones. A frame takes effect only at the rising edge of SS, and only when exactly sixteen falling edges were counted while SS was low. A valid diagnostic read ends with a one-cycle pulse, which the surrounding logic uses to clear its diagnostic state.

Top module: `spi_frame_slave`

## Requirements
- R1: After reset, or when reset is applied in the middle of a frame, `so_oe_o` and `diag_read_done_o` are 0 and the error flag is 0.
- R2: `so_oe_o` is 0 while SS is high and during the first two SCK rises of a frame. It turns on from the third rise only when the first two SI bits equal the chip address 00.
- R3: A frame whose first two SI bits are not 00 leaves `so_oe_o` at 0 for the whole frame and gives no done pulse. It leaves the error flag unchanged.
- R4: The first reply byte, sent MSB first, is two undriven bits, then 1,0,1,0,1, then the error flag in the last bit position.
- R5: Instruction code 00000 in instruction bits 5..1 returns A1h as the second reply byte.
- R6: Instruction code 00001 returns the revision byte 00h (upper nibble software revision, lower nibble mask revision).
- R7: Instruction code 00100 returns `diag_i` as it is at the eighth falling SCK edge.
- R8: Any other instruction code returns FFh and sets the error flag for the next frame. It gives no done pulse.
- R9: An SS rising edge after a falling-SCK count other than 16 sets the error flag and gives no done pulse. Counts of 0 or 1 are included.
- R10: An addressed frame of exactly 16 clocks with a used instruction code clears the error flag.
- R11: A valid code-00100 frame produces `diag_read_done_o` high for exactly one system clock after SS rises.
- R12: Instruction bit 0 and the SI bits of the second byte do not change the reply.
- R13: SO changes only after a rising SCK edge. Reply bits leave MSB first, one per SCK period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, at least 8x SCK |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sck_i | input | 1 | Serial clock, idle low |
| ss_ni | input | 1 | Slave select, active low |
| si_i | input | 1 | Serial data in |
| diag_i | input | 8 | Diagnostic byte offered for code 00100 |
| so_o | output | 1 | Serial data out |
| so_oe_o | output | 1 | Drive enable for SO (0 = high impedance) |
| diag_read_done_o | output | 1 | One-cycle pulse after a valid diagnostic read |

## Verification
A stuck or miscounted bit counter shows up within one frame at the ports. The check byte comes out shifted, or the drive enable rises on the wrong SCK period. Errors in the flag or in the commit logic show up one frame later, in the last bit of the next check byte, or as a missing or extra done pulse a few cycles after SS rises. The bench sends frames with matching and foreign addresses, with used and unused codes, and with 0, 10, 16 and 20 clocks. It compares every sampled SO bit and enable bit with a model of the flag.

// File: rtl/spi_frame_pkg.sv
package spi_frame_pkg;
  localparam int ADDR_W = 2;
  localparam int OP_W   = 5;
  localparam logic [4:0] CHECK_FIXED = 5'b10101;
  localparam logic [7:0] FILL_BYTE   = 8'hFF;

  typedef enum logic [1:0] {OP_IDENT, OP_REV, OP_DIAG, OP_NONE} op_e;

  function automatic op_e decode_op(input logic [OP_W-1:0] code);
    case (code)
      5'b00000: decode_op = OP_IDENT;
      5'b00001: decode_op = OP_REV;
      5'b00100: decode_op = OP_DIAG;
      default:  decode_op = OP_NONE;
    endcase
  endfunction
endpackage

// File: rtl/spi_in_sync.sv
module spi_in_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sck_i,
  input  logic ss_ni,
  input  logic si_i,
  output logic sck_rise_o,
  output logic sck_fall_o,
  output logic ss_o,
  output logic ss_rise_o,
  output logic si_o
);
  // packed as {sck, ss, si}; ss resets inactive (high)
  localparam logic [2:0] RST_V = 3'b010;

  logic [STAGES-1:0][2:0] stg_q;
  logic [2:0] last, prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stg_q  <= {STAGES{RST_V}};
      prev_q <= RST_V;
    end else begin
      stg_q[0] <= {sck_i, ss_ni, si_i};
      for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
      prev_q <= stg_q[STAGES-1];
    end
  end

  assign last       = stg_q[STAGES-1];
  assign sck_rise_o = last[2] & ~prev_q[2];
  assign sck_fall_o = ~last[2] & prev_q[2];
  assign ss_o       = last[1];
  assign ss_rise_o  = last[1] & ~prev_q[1];
  assign si_o       = last[0];
endmodule

// File: rtl/spi_frame_ctrl.sv
module spi_frame_ctrl
  import spi_frame_pkg::*;
#(
  parameter int FRAME_BITS = 16,
  parameter logic [ADDR_W-1:0] CHIP_ADDR = '0,
  parameter logic [7:0] ID_VALUE  = 8'hA1,
  parameter logic [7:0] REV_VALUE = 8'h00,
  localparam int CNT_W = $clog2(FRAME_BITS + 2)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sck_fall_i,
  input  logic             ss_i,
  input  logic             ss_rise_i,
  input  logic             si_i,
  input  logic [7:0]       diag_i,
  output logic [CNT_W-1:0] fall_cnt_o,
  output logic             addr_ok_o,
  output logic [7:0]       data_o,
  output logic             err_flag_o,
  output logic             done_o
);
  localparam int BYTE_W = FRAME_BITS / 2;
  localparam logic [CNT_W-1:0] CNT_SAT    = CNT_W'(FRAME_BITS + 1);
  localparam logic [CNT_W-1:0] CNT_FULL   = CNT_W'(FRAME_BITS);
  localparam logic [CNT_W-1:0] CNT_ADDR   = CNT_W'(ADDR_W);
  localparam logic [CNT_W-1:0] ADDR_LAST  = CNT_W'(ADDR_W - 1);
  localparam logic [CNT_W-1:0] INSTR_LAST = CNT_W'(BYTE_W - 1);

  logic [CNT_W-1:0]  cnt_q;
  logic [BYTE_W-1:0] instr_q, instr_nx;
  logic              addr_ok_q, err_q, done_q, frame_ok, skip;
  logic [7:0]        data_q, data_nx;
  op_e               op_q, op_nx;

  assign instr_nx = {instr_q[BYTE_W-2:0], si_i};
  assign op_nx    = decode_op(instr_nx[OP_W:1]);

  always_comb begin
    case (op_nx)
      OP_IDENT: data_nx = ID_VALUE;
      OP_REV:   data_nx = REV_VALUE;
      OP_DIAG:  data_nx = diag_i;
      default:  data_nx = FILL_BYTE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q     <= '0;
      instr_q   <= '0;
      addr_ok_q <= 1'b0;
      op_q      <= OP_NONE;
      data_q    <= FILL_BYTE;
    end else if (ss_i) begin
      cnt_q <= '0;
    end else if (sck_fall_i) begin
      if (cnt_q != CNT_SAT) cnt_q <= cnt_q + 1'b1;
      if (cnt_q < CNT_W'(BYTE_W)) instr_q <= instr_nx;
      if (cnt_q == ADDR_LAST) addr_ok_q <= (instr_nx[ADDR_W-1:0] == CHIP_ADDR);
      if (cnt_q == INSTR_LAST) begin
        op_q   <= op_nx;
        data_q <= data_nx;
      end
    end
  end

  // a frame is foreign only once its address is known
  assign skip     = (cnt_q >= CNT_ADDR) && !addr_ok_q;
  assign frame_ok = (cnt_q == CNT_FULL) && (op_q != OP_NONE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      err_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (ss_rise_i && !skip) begin
        err_q  <= !frame_ok;
        done_q <= frame_ok && (op_q == OP_DIAG);
      end
    end
  end

  assign fall_cnt_o = cnt_q;
  assign addr_ok_o  = addr_ok_q;
  assign data_o     = data_q;
  assign err_flag_o = err_q;
  assign done_o     = done_q;
endmodule

// File: rtl/spi_tx_path.sv
module spi_tx_path
  import spi_frame_pkg::*;
#(
  parameter int FRAME_BITS = 16,
  localparam int CNT_W = $clog2(FRAME_BITS + 2)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sck_rise_i,
  input  logic             ss_i,
  input  logic [CNT_W-1:0] fall_cnt_i,
  input  logic             addr_ok_i,
  input  logic             err_flag_i,
  input  logic [7:0]       data_i,
  output logic             so_o,
  output logic             so_oe_o
);
  localparam int IDX_W = $clog2(FRAME_BITS);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_BITS);
  localparam logic [CNT_W-1:0] CNT_ADDR = CNT_W'(ADDR_W);

  logic [FRAME_BITS-1:0] reply;
  logic [IDX_W-1:0]      pos;
  logic                  so_q, oe_q;

  assign reply = {{ADDR_W{1'b0}}, CHECK_FIXED, err_flag_i, data_i};
  assign pos   = IDX_W'(FRAME_BITS - 1) - fall_cnt_i[IDX_W-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      so_q <= 1'b0;
      oe_q <= 1'b0;
    end else begin
      if (sck_rise_i && !ss_i) so_q <= (fall_cnt_i < CNT_FULL) ? reply[pos] : 1'b1;
      if (ss_i) oe_q <= 1'b0;
      else if (sck_rise_i && fall_cnt_i >= CNT_ADDR && addr_ok_i) oe_q <= 1'b1;
    end
  end

  assign so_o    = so_q;
  assign so_oe_o = oe_q;
endmodule

// File: rtl/spi_frame_slave.sv
module spi_frame_slave
  import spi_frame_pkg::*;
#(
  parameter int FRAME_BITS  = 16,
  parameter int SYNC_STAGES = 2,
  parameter logic [ADDR_W-1:0] CHIP_ADDR = '0,
  parameter logic [7:0] ID_VALUE  = 8'hA1,
  parameter logic [7:0] REV_VALUE = 8'h00
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       sck_i,
  input  logic       ss_ni,
  input  logic       si_i,
  input  logic [7:0] diag_i,
  output logic       so_o,
  output logic       so_oe_o,
  output logic       diag_read_done_o
);
  localparam int CNT_W = $clog2(FRAME_BITS + 2);

  logic             sck_rise, sck_fall, ss_s, ss_rise, si_s;
  logic [CNT_W-1:0] fall_cnt;
  logic             addr_ok, err_flag;
  logic [7:0]       data_byte;

  spi_in_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .sck_i, .ss_ni, .si_i,
    .sck_rise_o(sck_rise), .sck_fall_o(sck_fall),
    .ss_o(ss_s), .ss_rise_o(ss_rise), .si_o(si_s)
  );

  spi_frame_ctrl #(
    .FRAME_BITS(FRAME_BITS), .CHIP_ADDR(CHIP_ADDR),
    .ID_VALUE(ID_VALUE), .REV_VALUE(REV_VALUE)
  ) u_ctrl (
    .clk_i, .rst_ni,
    .sck_fall_i(sck_fall), .ss_i(ss_s), .ss_rise_i(ss_rise), .si_i(si_s),
    .diag_i,
    .fall_cnt_o(fall_cnt), .addr_ok_o(addr_ok), .data_o(data_byte),
    .err_flag_o(err_flag), .done_o(diag_read_done_o)
  );

  spi_tx_path #(.FRAME_BITS(FRAME_BITS)) u_tx (
    .clk_i, .rst_ni,
    .sck_rise_i(sck_rise), .ss_i(ss_s), .fall_cnt_i(fall_cnt),
    .addr_ok_i(addr_ok), .err_flag_i(err_flag), .data_i(data_byte),
    .so_o, .so_oe_o
  );
endmodule

// File: rtl/spi_frame_slave_chk.sv
module spi_frame_slave_chk #(
  parameter int CNT_W = 5
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             ss_s,
  input logic             sck_rise,
  input logic [CNT_W-1:0] fall_cnt,
  input logic             err_flag,
  input logic             so_o,
  input logic             so_oe_o,
  input logic             diag_read_done_o
);
  p_oe_idle_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ss_s |=> !so_oe_o);
  p_oe_after_addr_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    so_oe_o |-> fall_cnt >= CNT_W'(2));
  p_flag_frozen_in_frame_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ss_s |=> $stable(err_flag));
  p_done_single_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    diag_read_done_o |=> !diag_read_done_o);
  p_done_when_released_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    diag_read_done_o |-> ss_s);
  p_so_moves_on_rise_r13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(so_o) |-> $past(sck_rise));
endmodule

bind spi_frame_slave spi_frame_slave_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i, .rst_ni, .ss_s, .sck_rise, .fall_cnt, .err_flag,
  .so_o, .so_oe_o, .diag_read_done_o
);

// File: tb/spi_frame_slave_test.sv
`timescale 1ns/1ps
module spi_frame_slave_test;
  logic clk = 1'b0, rst_ni = 1'b0, sck = 1'b0, ss_n = 1'b1, si = 1'b0;
  logic [7:0] diag_val = 8'h00;
  logic so, so_oe, done;
  int tests = 0, fails = 0;
  bit model_flag = 1'b0;

  typedef struct {
    logic [15:0] oe;
    logic [15:0] so;
    int          nclk;
    bit          done;
    string       tag;
  } exp_t;
  exp_t exp_q[$];

  logic [15:0] cap_oe, cap_so;
  int mcnt = 0, done_cnt = 0;

  always #10 clk = ~clk;

  spi_frame_slave uut (
    .clk_i(clk), .rst_ni(rst_ni), .sck_i(sck), .ss_ni(ss_n), .si_i(si),
    .diag_i(diag_val), .so_o(so), .so_oe_o(so_oe), .diag_read_done_o(done)
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [15:0] got, input logic [15:0] expv);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: got %h exp %h", tag, what, got, expv);
    end
  endtask

  task automatic wclk(input int n);
    repeat (n) @(negedge clk);
  endtask

  // driver: computes the expected reply from the requirements, then drives the frame
  task automatic frame(input logic [15:0] word, input int nclk, input string tag);
    logic [4:0] code;
    logic [7:0] d;
    bit   used;
    exp_t e;
    code = word[13:9];
    used = (code == 5'd0) || (code == 5'd1) || (code == 5'd4);
    case (code)
      5'd0:    d = 8'hA1;
      5'd1:    d = 8'h00;
      5'd4:    d = diag_val;
      default: d = 8'hFF;
    endcase
    e.nclk = nclk;
    e.tag  = tag;
    if (nclk >= 2 && word[15:14] != 2'b00) begin
      e.oe = '0; e.so = '0; e.done = 1'b0;
    end else begin
      e.oe   = 16'h3FFF;
      e.so   = {8'h2A | {7'd0, model_flag}, d};
      e.done = (nclk == 16) && (code == 5'd4);
      model_flag = !((nclk == 16) && used);
    end
    exp_q.push_back(e);
    ss_n = 1'b0;
    wclk(8);
    for (int i = 0; i < nclk; i++) begin
      sck = 1'b1;
      si  = (i < 16) ? word[15-i] : 1'b0;
      wclk(8);
      sck = 1'b0;
      wclk(8);
    end
    wclk(8);
    ss_n = 1'b1;
    wclk(24);
    chk(so_oe == 1'b0, "R2", "oe while idle", {15'd0, so_oe}, 16'd0);
  endtask

  // monitor: captures SO at each falling SCK, compares after SS rises
  always @(negedge ss_n) begin
    mcnt = 0;
    done_cnt = 0;
  end
  always @(negedge sck) begin
    if (!ss_n) begin
      if (mcnt < 16) begin
        cap_oe[15-mcnt] = so_oe;
        cap_so[15-mcnt] = so;
      end
      mcnt++;
    end
  end
  always @(posedge clk) if (rst_ni && done) done_cnt++;

  always @(posedge ss_n) begin
    exp_t e;
    logic [15:0] mask;
    repeat (8) @(negedge clk);
    if (exp_q.size() > 0) begin
      e = exp_q.pop_front();
      mask = '0;
      for (int j = 0; j < 16; j++) if (j < e.nclk) mask[15-j] = 1'b1;
      chk((cap_oe & mask) == (e.oe & mask), e.tag, "drive enable", cap_oe & mask, e.oe & mask);
      chk(((cap_so ^ e.so) & e.oe & mask) == 16'd0, e.tag, "reply",
          cap_so & e.oe & mask, e.so & e.oe & mask);
      chk(done_cnt == (e.done ? 1 : 0), e.tag, "done pulse cycles",
          16'(done_cnt), {15'd0, e.done});
    end
  end

  initial begin
    #4_000_000;
    fails++;
    $display("FAIL watchdog: got timeout exp completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    wclk(3);
    chk(so_oe == 1'b0, "R1", "oe in reset", {15'd0, so_oe}, 16'd0);
    rst_ni = 1'b1;
    wclk(4);
    chk(done == 1'b0, "R1", "done after reset", {15'd0, done}, 16'd0);

    frame(16'h0000, 16, "R4 R5 R2 R13");
    frame(16'h0200, 16, "R6");
    diag_val = 8'h5C;
    frame(16'h0800, 16, "R7 R11");
    diag_val = 8'h3A;
    frame(16'h09FF, 16, "R12 R7");
    frame(16'h0400, 16, "R8");
    frame(16'h0000, 16, "R8 R10 flag set");
    frame(16'h0000, 16, "R10 flag cleared");
    frame(16'h0800, 10, "R9 short");
    frame(16'h0000, 16, "R9 flag after short");
    frame(16'h0000, 20, "R9 long");
    frame(16'h4000, 16, "R3 foreign");
    frame(16'hC800, 16, "R3 foreign diag");
    frame(16'h0200, 16, "R3 flag kept");
    frame(16'h0000, 0, "R9 no clocks");
    frame(16'h0000, 16, "R9 flag after empty");

    // reset in mid frame
    frame(16'h1E00, 16, "R8 prepare flag");
    ss_n = 1'b0;
    wclk(8);
    for (int i = 0; i < 4; i++) begin
      sck = 1'b1; si = 1'b0; wclk(8);
      sck = 1'b0; wclk(8);
    end
    rst_ni = 1'b0;
    wclk(2);
    chk(so_oe == 1'b0, "R1", "oe under mid-frame reset", {15'd0, so_oe}, 16'd0);
    ss_n = 1'b1;
    wclk(16);
    rst_ni = 1'b1;
    model_flag = 1'b0;
    wclk(8);
    frame(16'h0000, 16, "R1 flag cleared by reset");

    wclk(16);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule